// File: doc/BRIEF.md
# Sv32 Translation Control and Permission Check

This block is the control unit between a processor's memory stage and two neighbours: a translation cache and a page-table walker. It accepts one 32-bit virtual address per handshake, together with an access kind (load, store or fetch) and the current privilege level. It then produces either a 34-bit physical address or a fault cause. When paging is off or the hart runs in machine mode, the address passes straight through.

With paging on, the unit presents the virtual page number to the cache, and the cache answers in the same cycle. On a hit, the permission check completes and the result is registered, so it appears in the following cycle. On a miss, the unit sends the root table address and page number to the walker. It then holds its ready output low until the walker returns a leaf entry or an error, or until a walker timeout expires. A usable leaf entry is written back to the cache and then checked like a hit.

Only one translation is outstanding at any time, so results leave in the order the requests were accepted.

Top module: `sv32x_xlate_ctrl`

## Requirements
- R1: Out of reset `req_ready_o` is 1 and `rsp_valid_o`, `walk_valid_o` and `ins_valid_o` are 0. While a miss is outstanding, `req_ready_o` is 0, so only one translation is in flight.
- R2: A request accepted on a cache hit gives `rsp_valid_o` for exactly one cycle, in the cycle after acceptance. When no fault applies, `rsp_paddr_o = {cache_ppn_i, vaddr[11:0]}`.
- R3: A request accepted on a miss gives a one-cycle `walk_valid_o` pulse in the cycle after acceptance. `walk_root_o` equals `{satp_i[21:0], 12'h000}` and `walk_vpn_o` equals `vaddr[31:12]`. `req_ready_o` stays 0 until the response.
- R4: After a miss, the response appears in the cycle after the cycle in which `walk_done_i` is 1.
- R5: If `walk_done_i` has not been seen during the TIMEOUT cycles that start with the `walk_valid_o` cycle (TIMEOUT defaults to 256), the unit responds in the next cycle with a fault of the request's kind. It does not insert into the cache.
- R6: Any of the following ends the request with a page fault of the request's kind and no cache insertion: a walker error, or a returned entry with V=0, with W=1 and R=0, or with R=0 and X=0. The entry's bit layout is V=0, R=1, W=2, X=3, U=4, G=5, A=6, D=7, and the PPN is in bits 31:10.
- R7: A load needs R, or it needs X with `mxr_i` set.
- R8: A store needs W. A fetch needs X.
- R9: In user mode, an access to a page whose U bit is clear faults.
- R10: In supervisor mode, a load or store to a U page faults unless `sum_i` is 1. A fetch from a U page always faults.
- R11: When a walk returns a usable entry, `ins_valid_o` pulses in the same cycle as the response, carrying the page number, PTE bits 31:10 and PTE bits 7:0. The insertion happens even if the permission check then faults.
- R12: When `satp_i[31]` is 0 or the privilege is machine (2'b11), the response comes one cycle after acceptance with `rsp_paddr_o = {2'b00, vaddr}` and cause none. No cache or walker activity takes place.
- R13: Encodings are as follows. The access kind is 00 for load, 01 for store, and 10 or 11 for fetch. Privilege is 00 for user, 01 or 10 for supervisor, and 11 for machine. The cause is 00 for none, 01 for load fault, 10 for store fault and 11 for fetch fault. `rsp_paddr_o` is 0 whenever the cause is not none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Unit can take a request |
| req_vaddr_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | Access kind |
| req_priv_i | input | 2 | Privilege level |
| satp_i | input | 32 | Translation control word: bit 31 enables paging, bits 21:0 hold the root page number |
| sum_i | input | 1 | Supervisor may touch user data pages |
| mxr_i | input | 1 | Executable pages are readable |
| rsp_valid_o | output | 1 | Result present (one cycle) |
| rsp_paddr_o | output | 34 | Physical address, 0 on fault |
| rsp_cause_o | output | 2 | Fault cause |
| cache_vpn_o | output | 20 | Page number looked up in the cache |
| cache_hit_i | input | 1 | Cache hit, same cycle |
| cache_ppn_i | input | 22 | Cached physical page number |
| cache_perm_i | input | 8 | Cached permission bits (PTE bits 7:0) |
| ins_valid_o | output | 1 | Write a new mapping into the cache |
| ins_vpn_o | output | 20 | Page number to store |
| ins_ppn_o | output | 22 | Physical page number to store |
| ins_perm_o | output | 8 | Permission bits to store |
| walk_valid_o | output | 1 | Walk request pulse |
| walk_root_o | output | 34 | Root table physical address |
| walk_vpn_o | output | 20 | Page number to walk |
| walk_done_i | input | 1 | Walker finished |
| walk_err_i | input | 1 | Walker reports an error |
| walk_pte_i | input | 32 | Leaf entry from the walker |

## Verification
Bypass and hit results are due in the first cycle after the accepting edge, and the walk pulse is due in that same cycle after a miss. A walker answer shows up in the cycle after `walk_done_i`, and a silent walker gives a fault exactly TIMEOUT cycles after the walk pulse. The bench drives inputs and samples outputs at the falling edge. It checks each result in precisely its due cycle, and for the walk and timeout cases it also confirms that `rsp_valid_o` is still low in the cycle before.

// File: rtl/sv32x_pkg.sv
package sv32x_pkg;

    localparam int VA_W   = 32;
    localparam int PA_W   = 34;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int PTE_W  = 32;
    localparam int PERM_W = 8;

    localparam logic [1:0] PRIV_USER = 2'b00;
    localparam logic [1:0] PRIV_MACH = 2'b11;

    localparam logic [1:0] KIND_LOAD  = 2'b00;
    localparam logic [1:0] KIND_STORE = 2'b01;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_LOAD  = 2'b01,
        CAUSE_STORE = 2'b10,
        CAUSE_FETCH = 2'b11
    } cause_e;

    typedef struct packed {
        logic d;
        logic a;
        logic g;
        logic u;
        logic x;
        logic w;
        logic r;
        logic v;
    } perm_t;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        cause_e          cause;
    } rsp_t;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
        logic [1:0]       kind;
        logic [1:0]       priv;
        logic             sum;
        logic             mxr;
    } held_req_t;

    function automatic cause_e cause_of(input logic [1:0] kind);
        if (kind == KIND_LOAD)       return CAUSE_LOAD;
        else if (kind == KIND_STORE) return CAUSE_STORE;
        else                         return CAUSE_FETCH;
    endfunction

    function automatic logic entry_unusable(input perm_t p);
        return !p.v || (p.w && !p.r) || (!p.r && !p.x);
    endfunction

endpackage

// File: rtl/sv32x_perm_chk.sv
module sv32x_perm_chk
    import sv32x_pkg::*;
(
    input  logic [PERM_W-1:0] perm_i,
    input  logic [1:0]        kind_i,
    input  logic [1:0]        priv_i,
    input  logic              sum_i,
    input  logic              mxr_i,
    output logic              fault_o
);
    perm_t p;
    logic  kind_ok;
    logic  mode_ok;

    assign p = perm_t'(perm_i);

    always_comb begin
        unique case (kind_i)
            KIND_LOAD:  kind_ok = p.r || (mxr_i && p.x);
            KIND_STORE: kind_ok = p.w;
            default:    kind_ok = p.x;
        endcase

        if (priv_i == PRIV_USER)
            mode_ok = p.u;
        else if (p.u)
            mode_ok = kind_i[1] ? 1'b0 : sum_i;
        else
            mode_ok = 1'b1;
    end

    assign fault_o = !(kind_ok && mode_ok);

    // R8
    always_comb begin
        store_needs_w_chk: assert (!(kind_i == KIND_STORE && !p.w) || fault_o);
    end

endmodule

// File: rtl/sv32x_walk_timer.sv
module sv32x_walk_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i)   cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = run_i && (cnt_q == LAST);

    // R5
    cnt_in_window_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST);

endmodule

// File: rtl/sv32x_xlate_ctrl.sv
module sv32x_xlate_ctrl
    import sv32x_pkg::*;
#(
    parameter int TIMEOUT = 256
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [VA_W-1:0]   req_vaddr_i,
    input  logic [1:0]        req_kind_i,
    input  logic [1:0]        req_priv_i,
    input  logic [31:0]       satp_i,
    input  logic              sum_i,
    input  logic              mxr_i,
    output logic              rsp_valid_o,
    output logic [PA_W-1:0]   rsp_paddr_o,
    output logic [1:0]        rsp_cause_o,
    output logic [VPN_W-1:0]  cache_vpn_o,
    input  logic              cache_hit_i,
    input  logic [PPN_W-1:0]  cache_ppn_i,
    input  logic [PERM_W-1:0] cache_perm_i,
    output logic              ins_valid_o,
    output logic [VPN_W-1:0]  ins_vpn_o,
    output logic [PPN_W-1:0]  ins_ppn_o,
    output logic [PERM_W-1:0] ins_perm_o,
    output logic              walk_valid_o,
    output logic [PA_W-1:0]   walk_root_o,
    output logic [VPN_W-1:0]  walk_vpn_o,
    input  logic              walk_done_i,
    input  logic              walk_err_i,
    input  logic [PTE_W-1:0]  walk_pte_i
);
    typedef enum logic {ST_IDLE, ST_WAIT} state_e;

    state_e             state_q;
    held_req_t          held_q;
    rsp_t               rsp_q;
    logic               walk_q;
    logic [PPN_W-1:0]   root_q;
    logic               ins_q;
    logic [PPN_W-1:0]   ins_ppn_q;
    logic [PERM_W-1:0]  ins_perm_q;

    logic               accept;
    logic               bypass;
    logic               expired;
    logic               chk_fault;
    logic [PERM_W-1:0]  chk_perm;
    logic [1:0]         chk_kind;
    logic [1:0]         chk_priv;
    logic               chk_sum;
    logic               chk_mxr;
    logic               bad_entry;

    assign req_ready_o = (state_q == ST_IDLE);
    assign accept      = req_valid_i && req_ready_o;
    assign bypass      = !satp_i[31] || (req_priv_i == PRIV_MACH);
    assign cache_vpn_o = req_vaddr_i[VA_W-1:OFF_W];
    assign bad_entry   = walk_err_i || entry_unusable(perm_t'(walk_pte_i[PERM_W-1:0]));

    // One checker serves both paths: live request on a hit, held request after a walk.
    always_comb begin
        if (state_q == ST_IDLE) begin
            chk_perm = cache_perm_i;
            chk_kind = req_kind_i;
            chk_priv = req_priv_i;
            chk_sum  = sum_i;
            chk_mxr  = mxr_i;
        end else begin
            chk_perm = walk_pte_i[PERM_W-1:0];
            chk_kind = held_q.kind;
            chk_priv = held_q.priv;
            chk_sum  = held_q.sum;
            chk_mxr  = held_q.mxr;
        end
    end

    sv32x_perm_chk u_perm (
        .perm_i  (chk_perm),
        .kind_i  (chk_kind),
        .priv_i  (chk_priv),
        .sum_i   (chk_sum),
        .mxr_i   (chk_mxr),
        .fault_o (chk_fault)
    );

    sv32x_walk_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (state_q == ST_WAIT),
        .expired_o (expired)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= ST_IDLE;
            held_q     <= '0;
            rsp_q      <= '0;
            walk_q     <= 1'b0;
            root_q     <= '0;
            ins_q      <= 1'b0;
            ins_ppn_q  <= '0;
            ins_perm_q <= '0;
        end else begin
            rsp_q.valid <= 1'b0;
            walk_q      <= 1'b0;
            ins_q       <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        held_q <= '{vpn:  req_vaddr_i[VA_W-1:OFF_W],
                                    off:  req_vaddr_i[OFF_W-1:0],
                                    kind: req_kind_i, priv: req_priv_i,
                                    sum:  sum_i, mxr: mxr_i};
                        if (bypass) begin
                            rsp_q <= '{valid: 1'b1, paddr: {2'b00, req_vaddr_i},
                                       cause: CAUSE_NONE};
                        end else if (cache_hit_i) begin
                            if (chk_fault)
                                rsp_q <= '{valid: 1'b1, paddr: '0,
                                           cause: cause_of(req_kind_i)};
                            else
                                rsp_q <= '{valid: 1'b1,
                                           paddr: {cache_ppn_i, req_vaddr_i[OFF_W-1:0]},
                                           cause: CAUSE_NONE};
                        end else begin
                            state_q <= ST_WAIT;
                            walk_q  <= 1'b1;
                            root_q  <= satp_i[PPN_W-1:0];
                        end
                    end
                end
                ST_WAIT: begin
                    if (walk_done_i) begin
                        state_q <= ST_IDLE;
                        if (bad_entry) begin
                            rsp_q <= '{valid: 1'b1, paddr: '0,
                                       cause: cause_of(held_q.kind)};
                        end else begin
                            ins_q      <= 1'b1;
                            ins_ppn_q  <= walk_pte_i[PTE_W-1:10];
                            ins_perm_q <= walk_pte_i[PERM_W-1:0];
                            if (chk_fault)
                                rsp_q <= '{valid: 1'b1, paddr: '0,
                                           cause: cause_of(held_q.kind)};
                            else
                                rsp_q <= '{valid: 1'b1,
                                           paddr: {walk_pte_i[PTE_W-1:10], held_q.off},
                                           cause: CAUSE_NONE};
                        end
                    end else if (expired) begin
                        state_q <= ST_IDLE;
                        rsp_q   <= '{valid: 1'b1, paddr: '0,
                                     cause: cause_of(held_q.kind)};
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid_o  = rsp_q.valid;
    assign rsp_paddr_o  = rsp_q.paddr;
    assign rsp_cause_o  = rsp_q.cause;
    assign walk_valid_o = walk_q;
    assign walk_root_o  = {root_q, {OFF_W{1'b0}}};
    assign walk_vpn_o   = held_q.vpn;
    assign ins_valid_o  = ins_q;
    assign ins_vpn_o    = held_q.vpn;
    assign ins_ppn_o    = ins_ppn_q;
    assign ins_perm_o   = ins_perm_q;

    // R13
    fault_zero_addr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rsp_valid_o && rsp_cause_o != 2'b00) |-> (rsp_paddr_o == '0));

    // R3
    walk_stalls_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        walk_valid_o |-> !req_ready_o);

    // R3
    walk_single_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        walk_valid_o |=> !walk_valid_o);

    // R11
    insert_with_rsp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ins_valid_o |-> rsp_valid_o);

    // R12
    bypass_passthru_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && req_ready_o && (!satp_i[31] || req_priv_i == 2'b11))
        |=> (rsp_valid_o && rsp_cause_o == 2'b00 &&
             rsp_paddr_o == {2'b00, $past(req_vaddr_i)} && !walk_valid_o));

endmodule

// File: tb/sv32x_xlate_ctrl_tb.sv
module sv32x_xlate_ctrl_tb;
    localparam int TO = 256;
    localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_IF = 2'b10;
    localparam logic [1:0] P_U = 2'b00, P_S = 2'b01, P_M = 2'b11;
    localparam logic [1:0] C_NONE = 2'b00, C_LD = 2'b01, C_ST = 2'b10, C_IF = 2'b11;
    localparam logic [7:0] B_V = 8'h01, B_R = 8'h02, B_W = 8'h04, B_X = 8'h08,
                           B_U = 8'h10, B_A = 8'h40;
    localparam logic [31:0] SATP_ON = 32'h8001_2345;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_priv = '0;
    logic [31:0] satp = '0;
    logic        sum = 1'b0;
    logic        mxr = 1'b0;
    logic        rsp_valid;
    logic [33:0] rsp_paddr;
    logic [1:0]  rsp_cause;
    logic [19:0] cache_vpn;
    logic        cache_hit = 1'b0;
    logic [21:0] cache_ppn = '0;
    logic [7:0]  cache_perm = '0;
    logic        ins_valid;
    logic [19:0] ins_vpn;
    logic [21:0] ins_ppn;
    logic [7:0]  ins_perm;
    logic        walk_valid;
    logic [33:0] walk_root;
    logic [19:0] walk_vpn;
    logic        walk_done = 1'b0;
    logic        walk_err = 1'b0;
    logic [31:0] walk_pte = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sv32x_xlate_ctrl #(.TIMEOUT(TO)) u_dut (
        .clk_i(clk), .rst_i(rst),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
        .req_kind_i(req_kind), .req_priv_i(req_priv), .satp_i(satp),
        .sum_i(sum), .mxr_i(mxr),
        .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_cause_o(rsp_cause),
        .cache_vpn_o(cache_vpn), .cache_hit_i(cache_hit), .cache_ppn_i(cache_ppn),
        .cache_perm_i(cache_perm),
        .ins_valid_o(ins_valid), .ins_vpn_o(ins_vpn), .ins_ppn_o(ins_ppn),
        .ins_perm_o(ins_perm),
        .walk_valid_o(walk_valid), .walk_root_o(walk_root), .walk_vpn_o(walk_vpn),
        .walk_done_i(walk_done), .walk_err_i(walk_err), .walk_pte_i(walk_pte)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_req(input logic [31:0] va, input logic [1:0] kind,
                           input logic [1:0] priv, input logic [31:0] s,
                           input logic su, input logic mx);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_priv = priv;
        satp = s; sum = su; mxr = mx;
    endtask

    // Single-cycle path: bypass or cache hit/miss decided in the accept cycle.
    task automatic run_single(input string tag, input logic [31:0] va, input logic [1:0] kind,
                              input logic [1:0] priv, input logic [31:0] s, input logic su,
                              input logic mx, input logic hit, input logic [21:0] ppn,
                              input logic [7:0] perm, input logic [33:0] exp_pa,
                              input logic [1:0] exp_cause);
        @(negedge clk);
        chk({tag, " ready before"}, 64'(req_ready), 64'd1);
        put_req(va, kind, priv, s, su, mx);
        cache_hit = hit; cache_ppn = ppn; cache_perm = perm;
        @(negedge clk);
        req_valid = 1'b0; cache_hit = 1'b0;
        chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " cause"}, 64'(rsp_cause), 64'(exp_cause));
        chk({tag, " paddr"}, 64'(rsp_paddr), 64'(exp_pa));
        chk({tag, " no walk"}, 64'(walk_valid), 64'd0);
    endtask

    task automatic run_miss(input string tag, input logic [31:0] va, input logic [1:0] kind,
                            input logic [1:0] priv, input logic su, input logic mx,
                            input int delay, input logic err, input logic [31:0] pte,
                            input logic [33:0] exp_pa, input logic [1:0] exp_cause,
                            input logic exp_ins);
        @(negedge clk);
        put_req(va, kind, priv, SATP_ON, su, mx);
        cache_hit = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R3 walk pulse"}, 64'(walk_valid), 64'd1);
        chk({tag, " R3 root"}, 64'(walk_root), 64'({SATP_ON[21:0], 12'h000}));
        chk({tag, " R3 vpn"}, 64'(walk_vpn), 64'(va[31:12]));
        chk({tag, " R1 stalled"}, 64'(req_ready), 64'd0);
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            chk({tag, " R4 quiet"}, 64'({req_ready, rsp_valid, walk_valid}), 64'd0);
        end
        walk_done = 1'b1; walk_err = err; walk_pte = pte;
        @(negedge clk);
        walk_done = 1'b0; walk_err = 1'b0;
        chk({tag, " R4 rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " cause"}, 64'(rsp_cause), 64'(exp_cause));
        chk({tag, " paddr"}, 64'(rsp_paddr), 64'(exp_pa));
        chk({tag, " R11 ins_valid"}, 64'(ins_valid), 64'(exp_ins));
        if (exp_ins) begin
            chk({tag, " R11 ins_vpn"}, 64'(ins_vpn), 64'(va[31:12]));
            chk({tag, " R11 ins_ppn"}, 64'(ins_ppn), 64'(pte[31:10]));
            chk({tag, " R11 ins_perm"}, 64'(ins_perm), 64'(pte[7:0]));
        end
        @(negedge clk);
        chk({tag, " R1 ready again"}, 64'(req_ready), 64'd1);
    endtask

    task automatic run_timeout(input string tag, input logic [31:0] va, input logic [1:0] kind,
                               input logic [1:0] exp_cause);
        @(negedge clk);
        put_req(va, kind, P_S, SATP_ON, 1'b0, 1'b0);
        cache_hit = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R5 walk pulse"}, 64'(walk_valid), 64'd1);
        for (int i = 1; i < TO; i++) @(negedge clk);
        chk({tag, " R5 not early"}, 64'({req_ready, rsp_valid}), 64'd0);
        @(negedge clk);
        chk({tag, " R5 rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " R5 cause"}, 64'(rsp_cause), 64'(exp_cause));
        chk({tag, " R5 paddr"}, 64'(rsp_paddr), 64'd0);
        chk({tag, " R5 no insert"}, 64'(ins_valid), 64'd0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1 reset ready", 64'(req_ready), 64'd1);
        chk("R1 reset outputs", 64'({rsp_valid, walk_valid, ins_valid}), 64'd0);
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        put_req(32'h0000_1AAA, K_LD, P_S, SATP_ON, 1'b0, 1'b0);
        cache_hit = 1'b1; cache_ppn = 22'h00_0111; cache_perm = B_V | B_R | B_A;
        @(negedge clk);
        chk("R2 first of pair", 64'(rsp_paddr), 64'({22'h00_0111, 12'hAAA}));
        req_vaddr = 32'h0000_2BBB; cache_ppn = 22'h00_0222;
        @(negedge clk);
        req_valid = 1'b0; cache_hit = 1'b0;
        chk("R2 second of pair", 64'(rsp_paddr), 64'({22'h00_0222, 12'hBBB}));
        @(negedge clk);
        chk("R2 single pulse", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
                $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        // R12 paging off, and machine mode with a useless cached entry
        run_single("R12 satp off", 32'hDEAD_B123, K_ST, P_S, 32'h0000_0000, 0, 0,
                   1'b0, '0, '0, {2'b00, 32'hDEAD_B123}, C_NONE);
        run_single("R12 machine", 32'h8765_4321, K_IF, P_M, SATP_ON, 0, 0,
                   1'b1, 22'h3F_FFFF, 8'h00, {2'b00, 32'h8765_4321}, C_NONE);
        // R2 hit
        run_single("R2 hit load", 32'h1234_5678, K_LD, P_S, SATP_ON, 0, 0,
                   1'b1, 22'h3F_0A5C, B_V | B_R | B_A, {22'h3F_0A5C, 12'h678}, C_NONE);
        test_back_to_back();
        // R8 / R13
        run_single("R8 store no W", 32'h0000_3004, K_ST, P_S, SATP_ON, 0, 0,
                   1'b1, 22'h00_0033, B_V | B_R, 34'd0, C_ST);
        run_single("R8 fetch no X", 32'h0000_4008, K_IF, P_S, SATP_ON, 0, 0,
                   1'b1, 22'h00_0044, B_V | B_R | B_W, 34'd0, C_IF);
        // R7
        run_single("R7 exec-only mxr0", 32'h0000_5010, K_LD, P_S, SATP_ON, 0, 0,
                   1'b1, 22'h00_0055, B_V | B_X, 34'd0, C_LD);
        run_single("R7 exec-only mxr1", 32'h0000_5010, K_LD, P_S, SATP_ON, 0, 1,
                   1'b1, 22'h00_0055, B_V | B_X, {22'h00_0055, 12'h010}, C_NONE);
        // R9
        run_single("R9 user no U", 32'h0000_6020, K_LD, P_U, SATP_ON, 0, 0,
                   1'b1, 22'h00_0066, B_V | B_R, 34'd0, C_LD);
        run_single("R9 user with U", 32'h0000_6020, K_LD, P_U, SATP_ON, 0, 0,
                   1'b1, 22'h00_0066, B_V | B_R | B_U, {22'h00_0066, 12'h020}, C_NONE);
        // R10
        run_single("R10 sup U sum0", 32'h0000_7030, K_ST, P_S, SATP_ON, 0, 0,
                   1'b1, 22'h00_0077, B_V | B_R | B_W | B_U, 34'd0, C_ST);
        run_single("R10 sup U sum1", 32'h0000_7030, K_ST, P_S, SATP_ON, 1, 0,
                   1'b1, 22'h00_0077, B_V | B_R | B_W | B_U, {22'h00_0077, 12'h030}, C_NONE);
        run_single("R10 sup fetch U", 32'h0000_7030, K_IF, P_S, SATP_ON, 1, 0,
                   1'b1, 22'h00_0077, B_V | B_X | B_U, 34'd0, C_IF);
        // R3 R4 R11 miss paths
        run_miss("R4 good walk", 32'hABCD_E0F0, K_LD, P_S, 0, 0, 5, 1'b0,
                 {22'h15_5AA5, 10'(B_V | B_R | B_A)}, {22'h15_5AA5, 12'h0F0}, C_NONE, 1'b1);
        run_miss("R4 immediate", 32'h0040_1FFF, K_IF, P_S, 0, 0, 0, 1'b0,
                 {22'h00_0321, 10'(B_V | B_X)}, {22'h00_0321, 12'hFFF}, C_NONE, 1'b1);
        run_miss("R11 perm fault inserts", 32'h0050_2000, K_ST, P_S, 0, 0, 2, 1'b0,
                 {22'h00_0999, 10'(B_V | B_R)}, 34'd0, C_ST, 1'b1);
        // R6
        run_miss("R6 walker error", 32'h0060_3000, K_LD, P_S, 0, 0, 3, 1'b1,
                 {22'h00_0111, 10'(B_V | B_R)}, 34'd0, C_LD, 1'b0);
        run_miss("R6 W without R", 32'h0070_4000, K_ST, P_S, 0, 0, 1, 1'b0,
                 {22'h00_0222, 10'(B_V | B_W)}, 34'd0, C_ST, 1'b0);
        run_miss("R6 not valid", 32'h0080_5000, K_IF, P_S, 0, 0, 1, 1'b0,
                 {22'h00_0333, 10'(B_R | B_X)}, 34'd0, C_IF, 1'b0);
        // R5
        run_timeout("R5 timeout", 32'h0090_6000, K_ST, C_ST);
        @(negedge clk);
        chk("R5 ready after timeout", 64'(req_ready), 64'd1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule